// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a peripheral clock from its input clock by an integer ratio that software programs through a small register port. A per-clock enable gates the output without cutting a high phase short. Every divisor change goes through a busy handshake. Software checks that the busy bits in the status word are clear, writes a divisor code, and polls again until the bits clear. The new ratio is then in effect.

Two code widths are available at build time. The narrow build uses a 5-bit code. The wide build uses a 6-bit code, and its top bit selects a fixed divide-by-64 prescaler. In both builds a code of zero selects the largest ratio of its range. The ratio and the gate state change only at the boundary between two output periods. The output therefore has no runt pulse or truncated phase. A ratio of one passes the input clock through.

Register map: address 0 is the read-only status word, address 1 is the gate enable, address 2 is the divisor code, and address 3 reads zero.

Top module: `pclk_divider`

## Requirements
- R1: After reset, clkOut is low and does not toggle, and addresses 0, 1 and 2 all read 0.
- R2: In the narrow build (CODE_W=5), codes 1 to 31 give an output period of that many input cycles, and code 0 gives 32 cycles.
- R3: In the wide build (CODE_W=6) with code bit 5 clear, codes 1 to 31 give that many input cycles, and code 0 gives 64 cycles.
- R4: In the wide build with code bit 5 set, the period is 64 times the value of bits 4:0 in input cycles. A value of 0 in bits 4:0 gives 64 cycles.
- R5: For a ratio N of 2 or more, clkOut rises with an input rising edge and stays high for floor(N/2) input cycles. For N=1, clkOut follows the input clock.
- R6: A divisor write sets status bit 3 (value 0x08), visible in the cycle after the write. The bit stays set until the output switches to the new ratio. Address 2 reads back the accepted code.
- R7: A divisor write made while status bit 3 is set is ignored. Both the read-back code and the output period stay those of the earlier write.
- R8: A ratio switch happens only at a period boundary. The last period at the old ratio completes in full, and no pulse narrower than half an input cycle ever appears.
- R9: Bit 0 of address 1 is the gate enable and reads back as written. Status bit 4 (value 0x10) is set while the output gate has not yet followed the enable. The gate changes only at a period boundary, so a high phase is never cut short. While gated off, clkOut stays low.
- R10: A divisor update completes, and status bit 3 clears, even while the output is gated off.
- R11: The status word is read-only. Writes to address 0 have no effect, and its bits other than 3 and 4 read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (parent) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register address |
| regWr | input | 1 | Write strobe, sampled on the rising edge of clk |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr (combinational) |
| clkOut | output | 1 | Divided and gated output clock |

## Verification
The bench sweeps every divisor code in both builds and measures the period and the high time of the resulting output. The sweep includes the zero codes and the prescaled codes, where a design with a wrong decode shows an off-by-one period or the wrong scale. It also covers ratio one, where a design without passthrough gives no clock or a half-rate clock.

Further tests switch the ratio and the gate just after a rising edge. A design that applies either change at once would cut the current high phase or period short and produce a runt pulse. A monitor flags any such pulse at any time.

The bench also issues a second divisor write while the first is pending. A design that accepts it would show the wrong read-back value and the wrong period. Finally, it updates the divisor while the gate is off, where a design that stalls its counter would never clear busy.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  // widest ratio: 64 * 31 = 1984 needs 11 bits
  localparam int RATIO_W = 11;

  localparam int ADDR_STAT = 0;
  localparam int ADDR_GATE = 1;
  localparam int ADDR_DIV  = 2;

  localparam int STAT_DIV_BIT  = 3;
  localparam int STAT_GATE_BIT = 4;

  localparam int PRESC_SHIFT = 6;

  typedef struct packed {
    logic               loadRatio;
    logic [RATIO_W-1:0] newRatio;
    logic               loadGate;
    logic               gateVal;
  } divStrobe_t;

endpackage

// File: rtl/pclk_div_ctrl.sv
module pclk_div_ctrl
  import pclk_div_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              atEnd,
  input  logic              runQ,
  output logic [DATA_W-1:0] regRdata,
  output divStrobe_t        strb,
  output logic              pendDiv,
  output logic [CODE_W-1:0] codeQ
);

  logic               enReqQ;
  logic               gateBusy;
  logic               wrDiv;
  logic               wrGate;
  logic [RATIO_W-1:0] ratioDec;
  logic               unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:CODE_W];

  assign wrDiv    = regWr && (regAddr == ADDR_W'(ADDR_DIV)) && !pendDiv;
  assign wrGate   = regWr && (regAddr == ADDR_W'(ADDR_GATE));
  assign gateBusy = (enReqQ != runQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ   <= '0;
      pendDiv <= 1'b0;
      enReqQ  <= 1'b0;
    end else begin
      if (wrDiv) begin
        codeQ   <= regWdata[CODE_W-1:0];
        pendDiv <= 1'b1;
      end else if (pendDiv && atEnd) begin
        pendDiv <= 1'b0;
      end
      if (wrGate) begin
        enReqQ <= regWdata[0];
      end
    end
  end

  generate
    if (CODE_W == 6) begin : g_presc
      logic [4:0] lowBits;
      assign lowBits = codeQ[4:0];
      always_comb begin
        if (lowBits == 5'd0) begin
          ratioDec = RATIO_W'(1 << PRESC_SHIFT);
        end else if (codeQ[5]) begin
          ratioDec = RATIO_W'({lowBits, 6'd0});
        end else begin
          ratioDec = RATIO_W'(lowBits);
        end
      end
    end else begin : g_plain
      always_comb begin
        if (codeQ == '0) begin
          ratioDec = RATIO_W'(1 << CODE_W);
        end else begin
          ratioDec = RATIO_W'(codeQ);
        end
      end
    end
  endgenerate

  always_comb begin
    strb.loadRatio = pendDiv && atEnd;
    strb.newRatio  = ratioDec;
    strb.loadGate  = atEnd;
    strb.gateVal   = enReqQ;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(ADDR_STAT): begin
        regRdata[STAT_DIV_BIT]  = pendDiv;
        regRdata[STAT_GATE_BIT] = gateBusy;
      end
      ADDR_W'(ADDR_GATE): regRdata[0] = enReqQ;
      ADDR_W'(ADDR_DIV):  regRdata[CODE_W-1:0] = codeQ;
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/pclk_div_path.sv
module pclk_div_path
  import pclk_div_pkg::*;
#(
  parameter int RESET_RATIO = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strb,
  output logic               clkOut,
  output logic               atEnd,
  output logic               runQ,
  output logic [RATIO_W-1:0] cntQ,
  output logic [RATIO_W-1:0] ratioQ
);

  logic [RATIO_W-1:0] cntNext;
  logic [RATIO_W-1:0] ratioNext;
  logic [RATIO_W-1:0] halfLen;
  logic               runNext;
  logic               hiNext;
  logic               loNext;
  logic               hiQ;
  logic               loQ;

  assign atEnd = (cntQ == ratioQ - RATIO_W'(1));

  // next-cycle state depends only on registered state, so the
  // falling-edge and rising-edge flops see the same value
  always_comb begin
    cntNext   = atEnd ? '0 : cntQ + RATIO_W'(1);
    ratioNext = strb.loadRatio ? strb.newRatio : ratioQ;
    runNext   = strb.loadGate ? strb.gateVal : runQ;
    halfLen   = ratioNext >> 1;
    if (ratioNext == RATIO_W'(1)) begin
      hiNext = runNext;
      loNext = 1'b0;
    end else begin
      hiNext = runNext && (cntNext < halfLen);
      loNext = hiNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      ratioQ <= RATIO_W'(RESET_RATIO);
      runQ   <= 1'b0;
      loQ    <= 1'b0;
    end else begin
      cntQ   <= cntNext;
      ratioQ <= ratioNext;
      runQ   <= runNext;
      loQ    <= loNext;
    end
  end

  // level for the coming high half of the input clock
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= 1'b0;
    end else begin
      hiQ <= hiNext;
    end
  end

  assign clkOut = clk ? hiQ : loQ;

endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
  import pclk_div_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              clkOut
);

  localparam int RESET_RATIO = 1 << CODE_W;

  divStrobe_t         strb;
  logic               atEnd;
  logic               runQ;
  logic               pendDiv;
  logic [CODE_W-1:0]  codeQ;
  logic [RATIO_W-1:0] cntQ;
  logic [RATIO_W-1:0] ratioQ;

  pclk_div_ctrl #(
    .CODE_W(CODE_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWr   (regWr),
    .regWdata(regWdata),
    .atEnd   (atEnd),
    .runQ    (runQ),
    .regRdata(regRdata),
    .strb    (strb),
    .pendDiv (pendDiv),
    .codeQ   (codeQ)
  );

  pclk_div_path #(
    .RESET_RATIO(RESET_RATIO)
  ) u_path (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .clkOut(clkOut),
    .atEnd (atEnd),
    .runQ  (runQ),
    .cntQ  (cntQ),
    .ratioQ(ratioQ)
  );

endmodule

// File: rtl/pclk_divider_chk.sv
module pclk_divider_chk
  import pclk_div_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWr,
  input logic [DATA_W-1:0]  regRdata,
  input logic               clkOut,
  input logic               pendDiv,
  input logic               runQ,
  input logic [CODE_W-1:0]  codeQ,
  input logic [RATIO_W-1:0] cntQ,
  input logic [RATIO_W-1:0] ratioQ
);

  // R6
  busy_from_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendDiv) |-> $past(regWr && (regAddr == ADDR_W'(ADDR_DIV))));

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendDiv && regWr && (regAddr == ADDR_W'(ADDR_DIV))) |=> $stable(codeQ));

  // R8
  commit_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendDiv) |-> (cntQ == '0));

  // R8
  ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ratioQ) |-> (cntQ == '0));

  // R8
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < ratioQ);

  // R9
  gate_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(runQ) |-> (cntQ == '0));

  // R9
  gated_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !clkOut);

  // R11
  status_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_STAT)) |-> ((regRdata[2:0] == 3'd0) && (regRdata[DATA_W-1:5] == '0)));

endmodule

bind pclk_divider pclk_divider_chk #(
  .CODE_W(CODE_W),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regWr   (regWr),
  .regRdata(regRdata),
  .clkOut  (clkOut),
  .pendDiv (pendDiv),
  .runQ    (runQ),
  .codeQ   (codeQ),
  .cntQ    (cntQ),
  .ratioQ  (ratioQ)
);

// File: tb/pclk_divider_bench.sv
`timescale 1ns/1ps
module pclk_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;

  logic [1:0] aAddr = 2'd0;
  logic       aWr = 1'b0;
  logic [7:0] aWdata = 8'd0;
  logic [7:0] aRdata;
  logic       aOut;

  logic [1:0] bAddr = 2'd0;
  logic       bWr = 1'b0;
  logic [7:0] bWdata = 8'd0;
  logic [7:0] bRdata;
  logic       bOut;

  logic sel = 1'b0;
  logic outSel;
  assign outSel = sel ? bOut : aOut;

  int nChecks = 0;
  int nFail = 0;
  int runts = 0;
  int riseA = 0;
  int riseB = 0;
  bit finished = 1'b0;

  always #(HALF) clk = ~clk;

  pclk_divider #(.CODE_W(5)) u_pclk_divider (
    .clk(clk), .rstN(rstN), .regAddr(aAddr), .regWr(aWr),
    .regWdata(aWdata), .regRdata(aRdata), .clkOut(aOut));

  pclk_divider #(.CODE_W(6)) u_pclk_divider_w (
    .clk(clk), .rstN(rstN), .regAddr(bAddr), .regWr(bWr),
    .regWdata(bWdata), .regRdata(bRdata), .clkOut(bOut));

  // runt monitors (R8)
  time lastRiseA = 0, lastFallA = 0, lastRiseB = 0, lastFallB = 0;
  always @(posedge aOut) begin
    riseA++;
    if (lastFallA != 0 && ($time - lastFallA) < HALF) runts++;
    lastRiseA = $time;
  end
  always @(negedge aOut) begin
    if (($time - lastRiseA) < HALF) runts++;
    lastFallA = $time;
  end
  always @(posedge bOut) begin
    riseB++;
    if (lastFallB != 0 && ($time - lastFallB) < HALF) runts++;
    lastRiseB = $time;
  end
  always @(negedge bOut) begin
    if (($time - lastRiseB) < HALF) runts++;
    lastFallB = $time;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int benchRatio(input int code, input bit wide);
    int low = code % 32;
    if (!wide) return (code == 0) ? 32 : code;
    if (low == 0) return 64;
    if (code >= 32) return 64 * low;
    return low;
  endfunction

  task automatic regWrite(input bit w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (w) begin bAddr = a; bWdata = d; bWr = 1'b1; end
    else begin aAddr = a; aWdata = d; aWr = 1'b1; end
    @(negedge clk);
    aWr = 1'b0;
    bWr = 1'b0;
  endtask

  task automatic regRead(input bit w, input logic [1:0] a, output logic [7:0] d);
    if (w) bAddr = a; else aAddr = a;
    #1;
    d = w ? bRdata : aRdata;
  endtask

  task automatic waitIdle(input bit w, input string req);
    logic [7:0] s;
    bit done = 1'b0;
    for (int i = 0; i < 5000 && !done; i++) begin
      @(negedge clk);
      regRead(w, 2'd0, s);
      if (s[4:3] == 2'b00) done = 1'b1;
    end
    if (!done) chk(1'b0, req, 1, 0);
  endtask

  task automatic measure(input bit w, output int perH, output int hiH);
    time t0, t1, t2;
    sel = w;
    @(posedge outSel); t0 = $time;
    @(negedge outSel); t1 = $time;
    @(posedge outSel); t2 = $time;
    perH = int'((t2 - t0) / HALF);
    hiH  = int'((t1 - t0) / HALF);
  endtask

  task automatic sweep(input bit w, input int codeW);
    logic [7:0] s;
    int n, perH, hiH;
    string req;
    for (int c = 0; c < (1 << codeW); c++) begin
      n = benchRatio(c, w);
      req = !w ? "R2" : ((c >= 32) ? "R4" : "R3");
      regWrite(w, 2'd2, 8'(c));
      regRead(w, 2'd0, s);
      chk(s[3] == 1'b1, "R6 busy after write", int'(s[3]), 1);
      waitIdle(w, "R6 busy clears");
      regRead(w, 2'd2, s);
      chk(s == 8'(c), "R6 readback", int'(s), c);
      measure(w, perH, hiH);
      chk(perH == 2 * n, req, perH, 2 * n);
      chk(hiH == ((n == 1) ? 1 : 2 * (n / 2)), "R5 high time", hiH,
          (n == 1) ? 1 : 2 * (n / 2));
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] s;
    int perH, hiH, r0;
    time t0, t1, t2, t3, t4;

    // R1 reset state
    repeat (4) @(negedge clk);
    chk(aOut == 1'b0 && bOut == 1'b0, "R1 output low in reset", int'(aOut | bOut), 0);
    rstN = 1'b1;
    repeat (80) @(negedge clk);
    chk(riseA == 0 && riseB == 0, "R1 no toggles after reset", riseA + riseB, 0);
    for (int a = 0; a < 3; a++) begin
      regRead(1'b0, 2'(a), s);
      chk(s == 8'd0, "R1 narrow reg reset", int'(s), 0);
      regRead(1'b1, 2'(a), s);
      chk(s == 8'd0, "R1 wide reg reset", int'(s), 0);
    end

    // R11 status read-only, address 3 reads zero
    regWrite(1'b0, 2'd0, 8'hFF);
    regRead(1'b0, 2'd0, s);
    chk(s == 8'd0, "R11 status write ignored", int'(s), 0);
    regRead(1'b0, 2'd3, s);
    chk(s == 8'd0, "R11 address 3", int'(s), 0);

    // R9 enable narrow
    regWrite(1'b0, 2'd1, 8'd1);
    regRead(1'b0, 2'd0, s);
    chk(s[4] == 1'b1, "R9 gate busy", int'(s[4]), 1);
    waitIdle(1'b0, "R9 gate busy clears");
    regRead(1'b0, 2'd1, s);
    chk(s == 8'd1, "R9 enable readback", int'(s), 1);

    sweep(1'b0, 5);

    // R7 write while busy ignored
    regWrite(1'b0, 2'd2, 8'd5);
    regWrite(1'b0, 2'd2, 8'd9);
    waitIdle(1'b0, "R7 idle");
    regRead(1'b0, 2'd2, s);
    chk(s == 8'd5, "R7 readback", int'(s), 5);
    measure(1'b0, perH, hiH);
    chk(perH == 10, "R7 period", perH, 10);

    // R8 switch 8 -> 3 right after a rising edge
    regWrite(1'b0, 2'd2, 8'd8);
    waitIdle(1'b0, "R8 idle");
    sel = 1'b0;
    @(posedge outSel); t0 = $time;
    regWrite(1'b0, 2'd2, 8'd3);
    @(negedge outSel); t1 = $time;
    @(posedge outSel); t2 = $time;
    @(negedge outSel); t3 = $time;
    @(posedge outSel); t4 = $time;
    chk((t1 - t0) == 8 * HALF, "R8 old high kept", int'(t1 - t0), 8 * HALF);
    chk((t2 - t0) == 16 * HALF, "R8 old period kept", int'(t2 - t0), 16 * HALF);
    chk((t4 - t2) == 6 * HALF && (t3 - t2) == 2 * HALF, "R8 new period",
        int'(t4 - t2), 6 * HALF);

    // R9 disable right after a rising edge
    regWrite(1'b0, 2'd2, 8'd10);
    waitIdle(1'b0, "R9 idle");
    @(posedge outSel); t0 = $time;
    regWrite(1'b0, 2'd1, 8'd0);
    regRead(1'b0, 2'd0, s);
    chk(s[4] == 1'b1, "R9 gate busy on disable", int'(s[4]), 1);
    @(negedge outSel); t1 = $time;
    chk((t1 - t0) == 10 * HALF, "R9 high not truncated", int'(t1 - t0), 10 * HALF);
    waitIdle(1'b0, "R9 disable idle");
    r0 = riseA;
    repeat (40) @(negedge clk);
    chk(riseA == r0 && aOut == 1'b0, "R9 gated off low", riseA - r0, 0);

    // R10 divisor update while gated off
    regWrite(1'b0, 2'd2, 8'd4);
    regRead(1'b0, 2'd0, s);
    chk(s[3] == 1'b1, "R10 busy while gated", int'(s[3]), 1);
    waitIdle(1'b0, "R10 busy clears while gated");
    regRead(1'b0, 2'd2, s);
    chk(s == 8'd4, "R10 readback", int'(s), 4);
    chk(riseA == r0, "R10 still gated", riseA - r0, 0);
    regWrite(1'b0, 2'd1, 8'd1);
    waitIdle(1'b0, "R10 enable idle");
    measure(1'b0, perH, hiH);
    chk(perH == 8 && hiH == 4, "R10 period after enable", perH, 8);

    // wide build
    regWrite(1'b1, 2'd1, 8'd1);
    waitIdle(1'b1, "R9 wide enable");
    sweep(1'b1, 6);

    chk(runts == 0, "R8 no runt pulses", runts, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule